// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a simple on-chip request port to an external asynchronous static RAM of 32K words by 8 bits. The RAM has active-low select, write and output-enable strobes and one shared data bus. A request carries an address, a direction flag and write data, and is taken through a valid/ready handshake. The controller then drives the strobes in a fixed order that meets the RAM's minimum pulse, setup and access times. Each interval is a whole number of clock cycles, rounded up from nanosecond parameters and the clock period.

A read asserts select and output enable for the access interval. The RAM's data is registered on the last access cycle and returned with a single-cycle valid pulse. The strobes are then released, and a turnaround gap follows so that the RAM's output drivers can reach high impedance before anything else happens on the bus. A write keeps output enable high for its whole length. It drives the bus from a setup cycle before the write strobe falls until a hold cycle after it rises. The bus is split into an output value, an output enable and an input value, so that the pad ring can build the tri-state buffer.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and req_ready is 1.
- R2: While no request is in progress, mem_cs_n, mem_we_n and mem_oe_n stay 1 and mem_dq_oe stays 0.
- R3: A read accepted at clock edge k holds mem_cs_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for the ACC cycles after edge k (ACC = ceil(max(70, 70) ns / 20 ns) = 4 at defaults).
- R4: For a read accepted at edge k, rd_valid is 1 for exactly one cycle, the one after edge k+ACC. In that cycle rd_data holds the value that mem_dq_i had at edge k+ACC.
- R5: After a read, mem_cs_n and mem_oe_n return to 1 and req_ready stays 0 for a gap of HZ cycles (HZ = ceil(25/20) = 2). So the RAM is released for at least 25 ns before the controller next drives the bus.
- R6: A write accepted at edge k gives one setup cycle with mem_cs_n=0 and mem_we_n=1. Then mem_we_n=0 for exactly WP cycles (WP = 3 at defaults, at least 50 ns), then one hold cycle with mem_cs_n=0 and mem_we_n=1. mem_we_n is low only while mem_cs_n is low.
- R7: mem_oe_n stays 1 for the whole write. mem_dq_oe is 1 in the setup, pulse and hold cycles with mem_dq_o equal to the request data, so the data is stable at least 30 ns before mem_we_n rises.
- R8: req_ready is 1 only in the idle state. A request that stays valid while req_ready is 0 is not started until the running access and its gap have ended, so requests are served in arrival order.
- R9: mem_addr equals the accepted request address and does not change while mem_cs_n is 0.
- R10: mem_dq_oe is never 1 while mem_oe_n is 0, and mem_we_n and mem_oe_n are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | DATA_W | Registered read data |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_i | input | DATA_W | Value read from the data bus |

## Verification
The bench's RAM model puts a garbage byte on the bus until 70 ns after select and output enable fall. A read sampled one cycle early therefore returns the wrong value. The model keeps driving for 25 ns after its enables rise, so a missing or short turnaround gap appears as bus contention when a write follows a read. The model also times every write strobe against the 50 ns pulse and 30 ns data-setup minimums, so a pulse one cycle short or data that arrives late is reported. A request held valid through a running write shows whether the controller starts it early or out of order.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctl_state_e;

    // strobe bundle as seen at the RAM pins
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // whole cycles needed to cover a time, never fewer than one
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int ACC_CYC = 4,
    parameter int WP_CYC  = 3,
    parameter int HZ_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output strobe_t          strobes
);
    localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LOAD  = CNT_W'(HZ_CYC - 1);

    ctl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = ACC_LOAD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    capture  = 1'b1;
                    state_d  = ST_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = HZ_LOAD;
                end
            end
            ST_TURN: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WP_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // strobe decode from the registered state only
    always_comb begin
        strobes = STROBE_OFF;
        unique case (state_q)
            ST_RD_ACC: begin
                strobes.cs_n = 1'b0;
                strobes.oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                strobes.cs_n  = 1'b0;
                strobes.drive = 1'b1;
            end
            ST_WR_PULSE: begin
                strobes.cs_n  = 1'b0;
                strobes.we_n  = 1'b0;
                strobes.drive = 1'b1;
            end
            default: strobes = STROBE_OFF;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= mem_dq_i;
        end
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign rd_valid = rvalid_q;
    assign rd_data  = rdata_q;
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 20,
    parameter int T_WP_NS = 50,
    parameter int T_DW_NS = 30,
    parameter int T_CW_NS = 60,
    parameter int T_WC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_RC_NS = 70,
    parameter int T_HZ_NS = 25,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // Write strobe length: pulse width and data setup directly; select-to-end
    // and cycle time less the setup and hold cycles that surround the pulse.
    localparam int WP_CYC = ns_to_cycles(
        max2(max2(T_WP_NS, T_DW_NS), max2(T_CW_NS - CLK_NS, T_WC_NS - 2 * CLK_NS)), CLK_NS);
    localparam int ACC_CYC = ns_to_cycles(max2(T_AA_NS, T_RC_NS), CLK_NS);
    localparam int HZ_CYC  = ns_to_cycles(T_HZ_NS, CLK_NS);

    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    strobe_t          strobes;

    sram_ctl_fsm #(
        .CNT_W  (CNT_W),
        .ACC_CYC(ACC_CYC),
        .WP_CYC (WP_CYC),
        .HZ_CYC (HZ_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tmr_expired(tmr_expired),
        .req_ready  (req_ready),
        .accept     (accept),
        .capture    (capture),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .strobes    (strobes)
    );

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .mem_dq_i (mem_dq_i),
        .mem_addr (mem_addr),
        .mem_dq_o (mem_dq_o),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign mem_cs_n  = strobes.cs_n;
    assign mem_we_n  = strobes.we_n;
    assign mem_oe_n  = strobes.oe_n;
    assign mem_dq_oe = strobes.drive;
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R2
    AST_READ_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R4
    AST_READ_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (mem_cs_n && mem_oe_n && !req_ready)); // R5
    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n); // R6
    AST_WE_RISE_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe)); // R6
    AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe)); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> !req_ready); // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr)); // R9
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n)); // R10
    AST_NO_WE_OE_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !mem_oe_n)); // R10
endmodule

bind sram_ctl sram_ctl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;
    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i = 8'hEE;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sram_ctl i_sram_ctl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- RAM model with timing ----------------
    logic [7:0] mdl_mem [256];
    realtime t_start = 0.0, t_off = -1000.0, t_wfall = 0.0, t_dchg = 0.0;
    logic drv_q = 1'b0, we_q = 1'b1, doe_q = 1'b0;
    logic [AW-1:0] addr_q = '0;
    logic [DW-1:0] dq_q = '0;

    initial begin
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'(i) ^ 8'h5A;
        #0.5;
        forever begin
            logic drive;
            drive = (mem_cs_n === 1'b0) && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
            if (drive && (!drv_q || mem_addr != addr_q)) t_start = $realtime;
            if (!drive && drv_q) t_off = $realtime;
            if (mem_dq_oe === 1'b1 && (doe_q !== 1'b1 || mem_dq_o != dq_q)) t_dchg = $realtime;
            if (we_q === 1'b1 && mem_we_n === 1'b0) t_wfall = $realtime;
            if (we_q === 1'b0 && mem_we_n === 1'b1 && mem_cs_n === 1'b0) begin
                // R6: write pulse width at least 50 ns
                check(($realtime - t_wfall) >= 50.0, "R6 we pulse ns",
                      32'($rtoi($realtime - t_wfall)), 32'd50);
                // R7: data driven and stable 30 ns before strobe end
                check(mem_dq_oe === 1'b1 && ($realtime - t_dchg) >= 30.0, "R7 data setup ns",
                      32'($rtoi($realtime - t_dchg)), 32'd30);
                mdl_mem[mem_addr[7:0]] = mem_dq_o;
            end
            if (mem_dq_oe === 1'b1 && (drive || ($realtime - t_off) < 25.0))
                check(1'b0, "R5 R10 bus contention", 32'(mem_dq_oe), 32'd0);
            drv_q = drive; we_q = mem_we_n; doe_q = mem_dq_oe;
            addr_q = mem_addr; dq_q = mem_dq_o;
            mem_dq_i = (drive && ($realtime - t_start) >= 70.0) ? mdl_mem[mem_addr[7:0]] : 8'hEE;
            #1;
        end
    end

    // ---------------- helpers ----------------
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset_idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes in reset",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
                  i == 0 ? "R1 after reset" : "R2 idle quiet",
                  {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);
        end
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue(1'b1, a, d);  // at cycle 1 after accept
        check(!mem_cs_n && mem_we_n && mem_oe_n && mem_dq_oe && !req_ready, "R6 setup cycle",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b01110);
        check(mem_dq_o == d && mem_addr == a, "R7 R9 write data/addr", {mem_addr, mem_dq_o}, {a, d});
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!mem_cs_n && !mem_we_n && mem_oe_n && mem_dq_oe && mem_addr == a,
                  "R6 R7 write pulse", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0011);
        end
        @(negedge clk);
        check(!mem_cs_n && mem_we_n && mem_dq_oe && !req_ready, "R6 hold cycle",
              {mem_cs_n, mem_we_n, mem_dq_oe, req_ready}, 4'b0110);
        @(negedge clk);
        check(mem_cs_n && !mem_dq_oe && req_ready, "R2 idle after write",
              {mem_cs_n, mem_dq_oe, req_ready}, 3'b101);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        issue(1'b0, a, 8'h00);
        for (int i = 0; i < 3; i++) begin
            if (i > 0) @(negedge clk);
            check(!mem_cs_n && !mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
                  "R3 read strobes", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid},
                  5'b00100);
            check(mem_addr == a, "R9 read address", 32'(mem_addr), 32'(a));
        end
        @(negedge clk);
        check(!mem_cs_n && !mem_oe_n, "R3 fourth access cycle", {mem_cs_n, mem_oe_n}, 2'b00);
        @(negedge clk);
        check(rd_valid && rd_data == exp, "R4 read data", {rd_valid, rd_data}, {1'b1, exp});
        check(mem_cs_n && mem_oe_n && !req_ready, "R5 gap cycle 1",
              {mem_cs_n, mem_oe_n, req_ready}, 3'b110);
        @(negedge clk);
        check(!rd_valid && !req_ready && mem_cs_n, "R4 R5 gap cycle 2",
              {rd_valid, req_ready, mem_cs_n}, 3'b001);
        @(negedge clk);
        check(req_ready, "R5 ready after gap", 32'(req_ready), 32'd1);
    endtask

    task automatic t_back_to_back();
        int waited;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0044; req_wdata = 8'h3C;
        @(posedge clk);
        @(negedge clk);
        // write accepted; present the next request at once and hold it
        req_write = 1'b0; req_wdata = 8'hFF;
        waited = 0;
        while (!req_ready) begin
            check(mem_oe_n && !(mem_we_n && waited >= 1 && waited <= 3),
                  "R8 read not started during write", {mem_oe_n, mem_we_n}, 2'b10);
            waited++;
            @(negedge clk);
        end
        check(waited == 5, "R8 busy cycles of write", 32'(waited), 32'd5);
        @(negedge clk);
        req_valid = 1'b0;
        check(!mem_cs_n && !mem_oe_n && mem_addr == 15'h0044, "R8 queued read started",
              {mem_cs_n, mem_oe_n}, 2'b00);
        repeat (4) @(negedge clk);
        check(rd_valid && rd_data == 8'h3C, "R8 in-order read data", {rd_valid, rd_data},
              {1'b1, 8'h3C});
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset_idle();
        t_read(15'h0012, 8'h12 ^ 8'h5A);
        t_write(15'h0003, 8'hA5);
        t_write(15'h0004, 8'h00);
        t_read(15'h0003, 8'hA5);
        t_read(15'h0004, 8'h00);
        t_write(15'h7FFF, 8'hFF);
        t_read(15'h7FFF, 8'hFF);
        t_read(15'h4A81, 8'h81 ^ 8'h5A);
        t_back_to_back();
        t_write(15'h0010, 8'h96);
        t_read(15'h0010, 8'h96);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule